// File: doc/BRIEF.md
# Shared Receive Packet FIFO for Device OUT Endpoints

This block holds received packets for every OUT endpoint of a device-side serial bus controller in one word-wide buffer. The link layer announces each packet with a 32-bit status word, then supplies the payload words, then closes the packet with a good or bad end strobe. At the announcement the block decides whether the packet fits. If it fits, the status word and the payload go into the buffer directly behind the previous packet. If it does not fit, the packet is refused whole, and a one-cycle refusal interrupt names the endpoint that was addressed.

The write side advances a tentative pointer. It makes the packet visible to software only when the packet ends well and carries exactly the payload it announced. Software reads the buffer through two pop strobes that share one read-data port. The first strobe removes a packet's status word. The second strobe removes that packet's payload words, one per pop. A level output stays high while at least one committed packet has not had its status popped.

The usable depth is set at run time in words. The buffer occupies addresses 0 up to that size minus one and wraps at the size.

Top module: `rx_pkt_fifo`

## Requirements
- R1: On `lnk_sop` with no packet in progress, the block needs 1 + ceil(byte count / 4) words, where the byte count is status bits [14:4]. It raises `lnk_accept` in the same cycle when that need is at most `free_words`, and raises `lnk_nack` otherwise. The two never assert together.
- R2: One cycle after a refusal, `nack_irq` pulses high for one cycle and `nack_ep` holds status bits [3:0] of the refused packet.
- R3: A status pop returns the oldest committed status word unchanged. The data pops that follow return that packet's payload words in write order. Packets come out in the order they were committed.
- R4: A status pop when no packet is pending, or while the current packet still has payload words left, returns 0 and changes no state.
- R5: A data pop after the current packet's payload is exhausted returns 0 and changes no state.
- R6: A packet is discarded and its space is returned in three cases: it ends with `lnk_eop_ok` low, its status valid flag (bit 17) is 0, or it carries fewer payload words than it announced.
- R7: `rx_nonempty` rises the cycle after a commit and stays high until the status word of the last pending packet has been popped.
- R8: `free_words` equals `cfg_size` minus the committed words not yet popped, minus the words already written for the packet in progress. After reset it equals `cfg_size`.
- R9: Payload words beyond the announced count are dropped and do not stop the packet from committing.
- R10: Storage wraps from address `cfg_size`-1 to 0 without corrupting the packets that cross the wrap.
- R11: An `lnk_sop` that arrives while a packet is in progress raises neither `lnk_accept` nor `lnk_nack` and does not disturb that packet.
- R12: After reset `rx_nonempty` and `nack_irq` are low, and a pop returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | AW+1 | Buffer size in words, 2 to DEPTH |
| lnk_sop | input | 1 | Packet announcement strobe |
| lnk_status | input | 32 | Status word: ep [3:0], bytes [14:4], PID [16:15], valid [17] |
| lnk_dvalid | input | 1 | Payload word strobe |
| lnk_data | input | 32 | Payload word |
| lnk_eop | input | 1 | End-of-packet strobe |
| lnk_eop_ok | input | 1 | Packet ended without error |
| lnk_accept | output | 1 | Announced packet is taken |
| lnk_nack | output | 1 | Announced packet is refused |
| nack_irq | output | 1 | Refusal interrupt pulse |
| nack_ep | output | 4 | Endpoint of the last refused packet |
| sw_stat_pop | input | 1 | Pop status word |
| sw_data_pop | input | 1 | Pop payload word (ignored when sw_stat_pop is high) |
| sw_rdata | output | 32 | Popped word, 0 when the pop is not taken |
| free_words | output | AW+1 | Free words |
| rx_nonempty | output | 1 | At least one packet pending |

## Verification
A wrong pointer or count shows up at the ports at once. If the tentative pointer fails to roll back, `free_words` stays low after an aborted packet. If the commit pointer is stale, the next status pop returns a status or payload word from somewhere else. If the remaining-payload count is wrong, the data pop right after the last payload word returns data where 0 is expected. Packets are pushed past the wrap point with sizes that land exactly on the free space, so a wrap error or an off-by-one in the fit test shows up within one packet.

// File: rtl/rx_pkt_fifo_pkg.sv
`timescale 1ns/1ps
package rx_pkt_fifo_pkg;

    localparam int WORD_W = 32;
    localparam int EP_W   = 4;
    localparam int BC_W   = 11;
    localparam int NEED_W = 12;

    typedef struct packed {
        logic [13:0]     rsvd;
        logic            ok;
        logic [1:0]      pid;
        logic [BC_W-1:0] bcnt;
        logic [EP_W-1:0] ep;
    } rx_stat_t;

    function automatic logic [BC_W-1:0] stat_bcnt(input logic [WORD_W-1:0] w);
        rx_stat_t s;
        s = rx_stat_t'(w);
        return s.bcnt;
    endfunction

    function automatic logic [EP_W-1:0] stat_ep(input logic [WORD_W-1:0] w);
        rx_stat_t s;
        s = rx_stat_t'(w);
        return s.ep;
    endfunction

    function automatic logic stat_ok(input logic [WORD_W-1:0] w);
        rx_stat_t s;
        s = rx_stat_t'(w);
        return s.ok;
    endfunction

    // payload words for a byte count: ceil(bytes / 4)
    function automatic logic [NEED_W-1:0] payload_words(input logic [BC_W-1:0] b);
        logic [NEED_W-1:0] t;
        t = {1'b0, b} + NEED_W'(3);
        return t >> 2;
    endfunction

endpackage

// File: rtl/rx_pkt_ram.sv
`timescale 1ns/1ps
module rx_pkt_ram #(
    parameter int AW = 5,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int N = 1 << AW;

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rx_pkt_wr_ctrl.sv
`timescale 1ns/1ps
module rx_pkt_wr_ctrl
    import rx_pkt_fifo_pkg::*;
#(
    parameter int AW = 5,
    parameter int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     cfg_size,
    input  logic [CW-1:0]     free_words,
    input  logic              sop,
    input  logic [WORD_W-1:0] status,
    input  logic              dvalid,
    input  logic [WORD_W-1:0] data,
    input  logic              eop,
    input  logic              eop_ok,
    output logic              accept,
    output logic              nack,
    output logic              nack_irq,
    output logic [EP_W-1:0]   nack_ep,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              commit,
    output logic [CW-1:0]     commit_words,
    output logic [CW-1:0]     pend_words
);
    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p,
                                               input logic [CW-1:0] sz);
        return (32'(p) + 1 >= 32'(sz)) ? '0 : p + 1'b1;
    endfunction

    logic              active;
    logic [AW-1:0]     wc, tp, tp_nx;
    logic [CW-1:0]     cnt, cnt_nx;
    logic [NEED_W-1:0] need, need_q;
    logic              ok_q, fits, take, close;

    always_comb begin
        need   = payload_words(stat_bcnt(status)) + NEED_W'(1);
        fits   = 32'(need) <= 32'(free_words);
        accept = sop && !active && fits;
        nack   = sop && !active && !fits;
        take   = active && dvalid && (32'(cnt) < 32'(need_q));
        cnt_nx = cnt + CW'(take);
        tp_nx  = take ? wrap_inc(tp, cfg_size) : tp;
        close  = active && eop;
        commit = close && eop_ok && ok_q && (32'(cnt_nx) == 32'(need_q));
        commit_words = cnt_nx;
        pend_words   = active ? cnt : '0;
        mem_we    = accept || take;
        mem_waddr = accept ? wc : tp;
        mem_wdata = accept ? status : data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            wc       <= '0;
            tp       <= '0;
            cnt      <= '0;
            need_q   <= '0;
            ok_q     <= 1'b0;
            nack_irq <= 1'b0;
            nack_ep  <= '0;
        end else begin
            nack_irq <= nack;
            if (nack) nack_ep <= stat_ep(status);
            if (accept) begin
                active <= 1'b1;
                tp     <= wrap_inc(wc, cfg_size);
                cnt    <= CW'(1);
                need_q <= need;
                ok_q   <= stat_ok(status);
            end else if (close) begin
                active <= 1'b0;
                cnt    <= '0;
                if (commit) begin
                    wc <= tp_nx;
                    tp <= tp_nx;
                end else begin
                    tp <= wc;
                end
            end else begin
                tp  <= tp_nx;
                cnt <= cnt_nx;
            end
        end
    end

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (rst)
        !(accept && nack)); // R1
    AST_WITHIN_RESERVE: assert property (@(posedge clk) disable iff (rst)
        active |-> (32'(cnt) <= 32'(need_q))); // R9
    AST_BUSY_SOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (active && sop) |-> (!accept && !nack)); // R11
endmodule

// File: rtl/rx_pkt_rd_ctrl.sv
`timescale 1ns/1ps
module rx_pkt_rd_ctrl
    import rx_pkt_fifo_pkg::*;
#(
    parameter int AW = 5,
    parameter int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     cfg_size,
    input  logic              stat_pop,
    input  logic              data_pop,
    input  logic              pkt_avail,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rd_word,
    output logic              stat_taken,
    output logic              word_taken
);
    logic [AW-1:0]     rptr, rptr_inc;
    logic [NEED_W-1:0] rem;
    logic              data_go;

    always_comb begin
        stat_taken = stat_pop && pkt_avail && (rem == '0);
        data_go    = data_pop && !stat_pop && (rem != '0);
        word_taken = stat_taken || data_go;
        rd_word    = word_taken ? mem_rdata : '0;
        rptr_inc   = (32'(rptr) + 1 >= 32'(cfg_size)) ? '0 : rptr + 1'b1;
        raddr      = rptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr <= '0;
            rem  <= '0;
        end else if (stat_taken) begin
            rptr <= rptr_inc;
            rem  <= payload_words(stat_bcnt(mem_rdata));
        end else if (data_go) begin
            rptr <= rptr_inc;
            rem  <= rem - 1'b1;
        end
    end

    AST_SPENT_DATA_POP: assert property (@(posedge clk) disable iff (rst)
        (data_pop && !stat_pop && rem == '0) |=> $stable(rptr)); // R5
    AST_BUSY_STAT_POP: assert property (@(posedge clk) disable iff (rst)
        (stat_pop && rem != '0) |=> ($stable(rptr) && rem == $past(rem))); // R4
endmodule

// File: rtl/rx_pkt_fifo.sv
`timescale 1ns/1ps
module rx_pkt_fifo
    import rx_pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_size,
    input  logic          lnk_sop,
    input  logic [31:0]   lnk_status,
    input  logic          lnk_dvalid,
    input  logic [31:0]   lnk_data,
    input  logic          lnk_eop,
    input  logic          lnk_eop_ok,
    output logic          lnk_accept,
    output logic          lnk_nack,
    output logic          nack_irq,
    output logic [3:0]    nack_ep,
    input  logic          sw_stat_pop,
    input  logic          sw_data_pop,
    output logic [31:0]   sw_rdata,
    output logic [CW-1:0] free_words,
    output logic          rx_nonempty
);
    logic              mem_we, commit, stat_taken, word_taken;
    logic [AW-1:0]     mem_waddr, raddr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;
    logic [CW-1:0]     commit_words, pend_words, occ, pkt_cnt;

    assign free_words  = cfg_size - occ - pend_words;
    assign rx_nonempty = (pkt_cnt != '0);

    rx_pkt_wr_ctrl #(.AW(AW), .CW(CW)) wr_i (
        .clk(clk), .rst(rst), .cfg_size(cfg_size), .free_words(free_words),
        .sop(lnk_sop), .status(lnk_status), .dvalid(lnk_dvalid), .data(lnk_data),
        .eop(lnk_eop), .eop_ok(lnk_eop_ok), .accept(lnk_accept), .nack(lnk_nack),
        .nack_irq(nack_irq), .nack_ep(nack_ep), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .commit(commit),
        .commit_words(commit_words), .pend_words(pend_words)
    );

    rx_pkt_rd_ctrl #(.AW(AW), .CW(CW)) rd_i (
        .clk(clk), .rst(rst), .cfg_size(cfg_size), .stat_pop(sw_stat_pop),
        .data_pop(sw_data_pop), .pkt_avail(rx_nonempty), .mem_rdata(mem_rdata),
        .raddr(raddr), .rd_word(sw_rdata), .stat_taken(stat_taken),
        .word_taken(word_taken)
    );

    rx_pkt_ram #(.AW(AW), .W(WORD_W)) ram_i (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(raddr), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            occ     <= '0;
            pkt_cnt <= '0;
        end else begin
            occ     <= occ + (commit ? commit_words : '0) - CW'(word_taken);
            pkt_cnt <= pkt_cnt + CW'(commit) - CW'(stat_taken);
        end
    end

    AST_SPACE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (32'(occ) + 32'(pend_words) <= 32'(cfg_size))); // R8
    AST_NONEMPTY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit |=> rx_nonempty); // R7
    AST_NACK_IRQ: assert property (@(posedge clk) disable iff (rst)
        lnk_nack |=> (nack_irq && nack_ep == $past(lnk_status[3:0]))); // R2
    AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (rst)
        (sw_stat_pop && !rx_nonempty && !lnk_sop && !lnk_dvalid && !lnk_eop)
        |=> (free_words == $past(free_words))); // R4
endmodule

// File: tb/rx_pkt_fifo_tb.sv
`timescale 1ns/1ps
module rx_pkt_fifo_tb_top;
    localparam int DEPTH = 32;
    localparam int CW    = $clog2(DEPTH) + 1;
    localparam int SIZE  = 16;

    typedef struct packed {
        logic [3:0]  ep;
        logic [10:0] bcnt;
        logic [1:0]  pid;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 11'd0,  2'd0},
        '{4'd2, 11'd3,  2'd2},
        '{4'd3, 11'd4,  2'd1},
        '{4'd4, 11'd21, 2'd3},
        '{4'd5, 11'd40, 2'd0},
        '{4'd6, 11'd60, 2'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CW-1:0] cfg_size = CW'(SIZE);
    logic lnk_sop = 0, lnk_dvalid = 0, lnk_eop = 0, lnk_eop_ok = 0;
    logic [31:0] lnk_status = '0, lnk_data = '0;
    logic sw_stat_pop = 0, sw_data_pop = 0;
    logic lnk_accept, lnk_nack, nack_irq, rx_nonempty;
    logic [3:0] nack_ep;
    logic [31:0] sw_rdata;
    logic [CW-1:0] free_words;

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    rx_pkt_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .cfg_size(cfg_size), .lnk_sop(lnk_sop),
        .lnk_status(lnk_status), .lnk_dvalid(lnk_dvalid), .lnk_data(lnk_data),
        .lnk_eop(lnk_eop), .lnk_eop_ok(lnk_eop_ok), .lnk_accept(lnk_accept),
        .lnk_nack(lnk_nack), .nack_irq(nack_irq), .nack_ep(nack_ep),
        .sw_stat_pop(sw_stat_pop), .sw_data_pop(sw_data_pop), .sw_rdata(sw_rdata),
        .free_words(free_words), .rx_nonempty(rx_nonempty)
    );

    function automatic logic [31:0] mk_stat(input int ep, input int bc, input int pid,
                                            input bit v);
        return {14'b0, v, 2'(pid), 11'(bc), 4'(ep)};
    endfunction

    function automatic logic [31:0] pat(input int ep, input int i, input int seed);
        return 32'hC0DE_0000 ^ 32'(ep << 12) ^ 32'(seed << 8) ^ 32'(i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_pkt(input logic [31:0] st, input int nw, input bit ok,
                            input bit exp_acc, input int seed);
        lnk_sop = 1; lnk_status = st;
        #1;
        chk("R1 accept", 32'(lnk_accept), 32'(exp_acc));
        chk("R1 nack", 32'(lnk_nack), 32'(!exp_acc));
        step();
        lnk_sop = 0;
        if (!exp_acc) begin
            chk("R2 irq", 32'(nack_irq), 32'd1);
            chk("R2 ep", 32'(nack_ep), 32'(st[3:0]));
            return;
        end
        for (int i = 0; i < nw; i++) begin
            lnk_dvalid = 1; lnk_data = pat(st[3:0], i, seed);
            step();
        end
        lnk_dvalid = 0;
        lnk_eop = 1; lnk_eop_ok = ok;
        step();
        lnk_eop = 0; lnk_eop_ok = 0;
    endtask

    task automatic pop(input bit stat, output logic [31:0] w);
        if (stat) sw_stat_pop = 1; else sw_data_pop = 1;
        #1;
        w = sw_rdata;
        step();
        sw_stat_pop = 0; sw_data_pop = 0;
    endtask

    task automatic drain(input logic [31:0] st, input int seed, input string req);
        logic [31:0] w;
        int nw;
        nw = (int'(st[14:4]) + 3) / 4;
        pop(1, w);
        chk({req, " status"}, w, st);
        for (int i = 0; i < nw; i++) begin
            pop(0, w);
            chk({req, " payload"}, w, pat(st[3:0], i, seed));
        end
        pop(0, w);
        chk("R5 spent data pop", w, 32'd0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(5.0 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        logic [31:0] w, s1, s2;
        step(); step();
        rst = 0;
        step();
        // R12 reset state
        chk("R12 nonempty", 32'(rx_nonempty), 32'd0);
        chk("R12 irq", 32'(nack_irq), 32'd0);
        chk("R8 free at reset", 32'(free_words), SIZE);
        pop(1, w);
        chk("R12 pop after reset", w, 32'd0);

        // table walk: write, read back, repeated past the wrap point (R10)
        for (int k = 0; k < NV; k++) begin
            int nw;
            s1 = mk_stat(VEC[k].ep, VEC[k].bcnt, VEC[k].pid, 1'b1);
            nw = (int'(VEC[k].bcnt) + 3) / 4;
            send_pkt(s1, nw, 1'b1, 1'b1, k);
            chk("R7 nonempty after commit", 32'(rx_nonempty), 32'd1);
            chk("R8 free after commit", 32'(free_words), SIZE - nw - 1);
            drain(s1, k, "R3 R10");
            chk("R7 clear after status pop", 32'(rx_nonempty), 32'd0);
            chk("R8 free after drain", 32'(free_words), SIZE);
        end

        // R1 / R2: one word too many is refused
        send_pkt(mk_stat(9, 61, 0, 1), 0, 1'b0, 1'b0, 0);
        step();
        chk("R2 irq one cycle", 32'(nack_irq), 32'd0);
        chk("R8 free after nack", 32'(free_words), SIZE);

        // R1 boundary: exact fit, then full buffer refuses a zero-length packet
        s1 = mk_stat(7, 60, 1, 1);
        send_pkt(s1, 15, 1'b1, 1'b1, 40);
        chk("R8 full", 32'(free_words), 32'd0);
        send_pkt(mk_stat(11, 0, 0, 1), 0, 1'b0, 1'b0, 0);
        // R4: status pop with payload pending
        pop(1, w);
        chk("R3 status full", w, s1);
        pop(1, w);
        chk("R4 status pop mid payload", w, 32'd0);
        for (int i = 0; i < 15; i++) begin
            pop(0, w);
            chk("R3 payload full", w, pat(7, i, 40));
        end
        pop(0, w);
        chk("R5 data pop past end", w, 32'd0);
        chk("R8 free restored", 32'(free_words), SIZE);
        pop(1, w);
        chk("R4 status pop empty", w, 32'd0);
        chk("R4 free unchanged", 32'(free_words), SIZE);

        // R6: bad end, invalid flag, short payload
        send_pkt(mk_stat(2, 8, 0, 1), 2, 1'b0, 1'b1, 50);
        chk("R6 abort not visible", 32'(rx_nonempty), 32'd0);
        chk("R6 abort space back", 32'(free_words), SIZE);
        send_pkt(mk_stat(2, 8, 0, 0), 2, 1'b1, 1'b1, 51);
        chk("R6 invalid not visible", 32'(rx_nonempty), 32'd0);
        send_pkt(mk_stat(2, 8, 0, 1), 1, 1'b1, 1'b1, 52);
        chk("R6 short not visible", 32'(rx_nonempty), 32'd0);
        chk("R6 short space back", 32'(free_words), SIZE);

        // R11: announcement during a packet
        s1 = mk_stat(3, 8, 2, 1);
        lnk_sop = 1; lnk_status = s1;
        #1;
        step();
        lnk_sop = 1; lnk_status = mk_stat(12, 4, 0, 1);
        #1;
        chk("R11 busy accept", 32'(lnk_accept), 32'd0);
        chk("R11 busy nack", 32'(lnk_nack), 32'd0);
        step();
        lnk_sop = 0;
        // R9: extra words dropped
        for (int i = 0; i < 4; i++) begin
            lnk_dvalid = 1; lnk_data = pat(3, i, 60);
            step();
        end
        lnk_dvalid = 0; lnk_eop = 1; lnk_eop_ok = 1;
        step();
        lnk_eop = 0; lnk_eop_ok = 0;
        chk("R9 committed", 32'(rx_nonempty), 32'd1);
        chk("R9 free", 32'(free_words), SIZE - 3);

        // second packet queued behind; order kept (R3, R7)
        s2 = mk_stat(13, 5, 1, 1);
        send_pkt(s2, 2, 1'b1, 1'b1, 61);
        drain(s1, 60, "R9 R3");
        chk("R7 still pending", 32'(rx_nonempty), 32'd1);
        drain(s2, 61, "R3 order");
        chk("R7 cleared", 32'(rx_nonempty), 32'd0);
        chk("R8 final free", 32'(free_words), SIZE);

        report();
        $finish;
    end
endmodule